// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the eight status bits of an asynchronous serial port. It sits between a simple processor register bus and the transmit and receive engines. The engines report single-cycle events: a character was received, its stop bit was low, its parity was wrong, a byte moved into the transmit shifter, and the final bit of a character left the line. They also supply the transmit-enable level and the multiprocessor bit of the received character. The block applies the set and clear rules to each flag and returns the flags and the stored multiprocessor transmit bit to the engines.

Software clears an error or data flag in two steps. It first reads the status register while the flag is 1, which arms that flag. It then writes a 0 to the flag's position. A write of 1 never sets a flag. Any write to the status register disarms every flag. If a hardware set event and a clear land in the same cycle, the flag ends up at 1.

Top module: `uart_stat_reg`

## Requirements
- R1: After reset, `status` reads 8'h84: bit 7 (transmit empty) and bit 2 (transmit end) are 1, and every other bit is 0.
- R2: Bits 7 to 3 clear only when a status write carries 0 in that position and a status read, made after the last status write, showed the bit as 1. Writing 1 never sets these bits. Every status write disarms all of them.
- R3: Bit 6 (receive full) is set when `rx_done` arrives with neither `rx_stop_low` nor `rx_par_bad` while bit 6 is 0. In that cycle bit 1 takes `rx_mpb`. Bit 6 clears on `rdr_read`.
- R4: Bit 5 (overrun) is set when `rx_done` arrives while bit 6 is 1. Bit 6 and bit 1 then keep their values.
- R5: `rx_done` with `rx_stop_low` sets bit 4 (framing). `rx_done` with `rx_par_bad` sets bit 3 (parity). Neither case sets bit 6. The two error inputs have no effect without `rx_done`.
- R6: Bit 7 is held at 1 while `tx_enable` is 0, and is set by `tx_load`. It is cleared by `tdr_write`.
- R7: Bit 2 is held at 1 while `tx_enable` is 0. It is also set by `tx_last` when bit 7 is 1. It is cleared by `tdr_write` or by a software clear of bit 7.
- R8: Bits 2 and 1 ignore status writes. Bit 0 is written from `reg_wdata[0]` on every status write and drives `mpb_tx`.
- R9: When a set event and a clear of the same flag occur in the same cycle, the flag is 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Status register read strobe |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Status write data |
| reg_rdata | output | 8 | Status read data |
| tdr_write | input | 1 | Software wrote the transmit data register |
| rdr_read | input | 1 | Software read the receive data register |
| tx_enable | input | 1 | Transmitter enable level |
| tx_load | input | 1 | Transmit byte moved into the shifter |
| tx_last | input | 1 | Last bit of a character sent |
| rx_done | input | 1 | Reception completed |
| rx_stop_low | input | 1 | Stop bit sampled as 0 (qualifies rx_done) |
| rx_par_bad | input | 1 | Parity mismatch (qualifies rx_done) |
| rx_mpb | input | 1 | Multiprocessor bit of the received character |
| status | output | 8 | Current flag vector |
| mpb_tx | output | 1 | Multiprocessor bit to transmit |

## Verification
The hardest case to reach from the ports is a software clear that arrives in the same cycle as a hardware set. The bench gets there in two steps. It first arms the framing flag with a status read. It then issues the zero write in the same cycle as a new erroneous reception, and checks that the flag is still 1. It also pairs a transmit-data write with a shifter load. The arming window is probed in a similar way: a write without a prior read must leave flags untouched, and a second zero write after a successful clear must do nothing.

// File: rtl/uart_stat_reg.sv
module uart_stat_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_rd,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tdr_write,
  input  logic       rdr_read,
  input  logic       tx_enable,
  input  logic       tx_load,
  input  logic       tx_last,
  input  logic       rx_done,
  input  logic       rx_stop_low,
  input  logic       rx_par_bad,
  input  logic       rx_mpb,
  output logic [7:0] status,
  output logic       mpb_tx
);

  logic       tdre, rdrf, oerr, ferr, perr, tend, mpbr, mpbt;
  logic [7:3] arm;

  wire [7:3] sw_clr = {5{reg_wr}} & arm & ~reg_wdata[7:3];

  wire tdre_set = ~tx_enable | tx_load;
  wire rdrf_set = rx_done & ~rx_stop_low & ~rx_par_bad & ~rdrf;
  wire oerr_set = rx_done & rdrf;
  wire ferr_set = rx_done & rx_stop_low;
  wire perr_set = rx_done & rx_par_bad;
  wire tend_set = ~tx_enable | (tx_last & tdre);

  assign status    = {tdre, rdrf, oerr, ferr, perr, tend, mpbr, mpbt};
  assign reg_rdata = status;
  assign mpb_tx    = mpbt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tdre <= 1'b1;
      rdrf <= 1'b0;
      oerr <= 1'b0;
      ferr <= 1'b0;
      perr <= 1'b0;
      tend <= 1'b1;
      mpbr <= 1'b0;
      mpbt <= 1'b0;
      arm  <= '0;
    end else begin
      tdre <= tdre_set | (tdre & ~tdr_write & ~sw_clr[7]);
      rdrf <= rdrf_set | (rdrf & ~rdr_read & ~sw_clr[6]);
      oerr <= oerr_set | (oerr & ~sw_clr[5]);
      ferr <= ferr_set | (ferr & ~sw_clr[4]);
      perr <= perr_set | (perr & ~sw_clr[3]);
      tend <= tend_set | (tend & ~tdr_write & ~sw_clr[7]);
      if (rdrf_set) mpbr <= rx_mpb;
      if (reg_wr)   mpbt <= reg_wdata[0];
      if (reg_wr)      arm <= '0;
      else if (reg_rd) arm <= arm | status[7:3];
    end
  end

endmodule

// File: rtl/uart_stat_reg_chk.sv
module uart_stat_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       tx_enable,
  input logic       rx_done,
  input logic       rx_stop_low,
  input logic [7:0] status,
  input logic       mpb_tx
);

  AST_RDRF_FROM_RX: assert property (@(posedge clk) disable iff (!rst_n) $rose(status[6]) |-> $past(rx_done)); // R3
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n) $rose(status[5]) |-> $past(rx_done && status[6])); // R4
  AST_FER_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n) $rose(status[4]) |-> $past(rx_done && rx_stop_low)); // R5
  AST_TX_OFF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) !tx_enable |=> (status[7] && status[2])); // R6
  AST_OVR_CLR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $fell(status[5]) |-> $past(reg_wr)); // R2
  AST_MPBT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !reg_wr |=> $stable(mpb_tx)); // R8
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (rx_done && rx_stop_low) |=> status[4]); // R9

endmodule

bind uart_stat_reg uart_stat_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .tx_enable(tx_enable),
  .rx_done(rx_done), .rx_stop_low(rx_stop_low), .status(status), .mpb_tx(mpb_tx)
);

// File: tb/uart_stat_reg_test.sv
module uart_stat_reg_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic reg_rd = 0, reg_wr = 0, tdr_write = 0, rdr_read = 0;
  logic tx_enable = 0, tx_load = 0, tx_last = 0;
  logic rx_done = 0, rx_stop_low = 0, rx_par_bad = 0, rx_mpb = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, status;
  logic mpb_tx;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_stat_reg uut (.*);

  typedef struct packed {
    logic rd, wr, tdrw, rdrr, ld, last, rx, stop, par, mpb;
  } op_t;

  task automatic step(op_t o, logic [7:0] wd, logic [7:0] exp, string tag);
    @(negedge clk);
    reg_rd = o.rd; reg_wr = o.wr; reg_wdata = wd; tdr_write = o.tdrw;
    rdr_read = o.rdrr; tx_load = o.ld; tx_last = o.last; rx_done = o.rx;
    rx_stop_low = o.stop; rx_par_bad = o.par; rx_mpb = o.mpb;
    @(posedge clk); #1;
    {reg_rd, reg_wr, tdr_write, rdr_read, tx_load, tx_last, rx_done, rx_stop_low, rx_par_bad, rx_mpb} = '0;
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      tests++;
      if (status !== e || mpb_tx !== status[0]) begin
        fails++;
        $display("FAIL %s: status=%h mpb_tx=%b expected status=%h", t, status, mpb_tx, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  localparam op_t NOP = '0;

  initial begin
    op_t o;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step(NOP, 0, 8'h84, "R1 reset value");
    step(NOP, 0, 8'h84, "R6 tx disabled holds flags");
    tx_enable = 1;
    step(NOP, 0, 8'h84, "R1 enabled idle");
    o = NOP; o.tdrw = 1; step(o, 0, 8'h00, "R6 R7 tdr write clears");
    o = NOP; o.ld = 1;   step(o, 0, 8'h80, "R6 load sets empty");
    o = NOP; o.last = 1; step(o, 0, 8'h84, "R7 last bit with empty");
    o = NOP; o.tdrw = 1; step(o, 0, 8'h00, "R7 tdr write");
    o = NOP; o.last = 1; step(o, 0, 8'h00, "R7 last bit while full");
    o = NOP; o.wr = 1;   step(o, 8'h01, 8'h01, "R8 mpb tx write");
    o = NOP; o.wr = 1;   step(o, 8'hFE, 8'h00, "R2 R8 ones do not set");
    o = NOP; o.stop = 1; o.par = 1; step(o, 0, 8'h00, "R5 errors without rx_done");
    o = NOP; o.rx = 1; o.mpb = 1; step(o, 0, 8'h42, "R3 clean receive");
    o = NOP; o.rx = 1; step(o, 0, 8'h62, "R4 overrun");
    o = NOP; o.wr = 1;   step(o, 8'h00, 8'h62, "R2 unarmed write");
    o = NOP; o.rd = 1;   step(o, 0, 8'h62, "R2 arming read");
    o = NOP; o.wr = 1;   step(o, 8'hDE, 8'h42, "R2 armed clear");
    o = NOP; o.wr = 1;   step(o, 8'h00, 8'h42, "R2 disarmed after write");
    o = NOP; o.rdrr = 1; step(o, 0, 8'h02, "R3 rdr read clears");
    o = NOP; o.rx = 1; o.stop = 1; step(o, 0, 8'h12, "R5 framing");
    o = NOP; o.rx = 1; o.par = 1;  step(o, 0, 8'h1A, "R5 parity");
    o = NOP; o.rd = 1;   step(o, 0, 8'h1A, "R2 arm errors");
    o = NOP; o.wr = 1;   step(o, 8'h00, 8'h02, "R2 errors cleared");
    o = NOP; o.rx = 1; o.stop = 1; step(o, 0, 8'h12, "R5 framing again");
    o = NOP; o.rd = 1;   step(o, 0, 8'h12, "R9 arm framing");
    o = NOP; o.wr = 1; o.rx = 1; o.stop = 1; step(o, 8'h00, 8'h12, "R9 set wins framing");
    o = NOP; o.tdrw = 1; o.ld = 1; step(o, 0, 8'h92, "R9 set wins empty");
    o = NOP; o.last = 1; step(o, 0, 8'h96, "R7 end set");
    o = NOP; o.rd = 1;   step(o, 0, 8'h96, "R7 arm empty");
    o = NOP; o.wr = 1;   step(o, 8'h7E, 8'h12, "R7 sw clear of empty clears end");
    tx_enable = 0;
    step(NOP, 0, 8'h96, "R6 R7 disable sets flags");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule